// File: doc/BRIEF.md
# Timed Self-Programming Command Window

This block holds the command register and the timing logic through which processor software sets boot lock bits and reads the fuse low byte and the lock byte back. Software writes a command code into the control register. A valid code opens a short window that is counted in clock cycles. A store strobe or a load strobe that arrives inside its part of the window is taken as the command. If no strobe arrives in time, the command drops on its own and the register goes back to idle.

While the load part of the window is open and no EEPROM write is in progress, an override flag tells the program-memory path to take the data from this block. Otherwise a load returns the normal program-memory data, passed through from an input. The four boot lock bits are kept in a register. They can only be cleared (programmed), never set again. The two general lock bits are taken from an input while reset is held.

Top module: `spm_cmd_window`

## Requirements
- R1: After reset, ld_override is 0, boot_lock is 4'b1111, lock_byte is {2'b11, 4'b1111, hw_lock sampled during reset}, and rd_data is 8'h00.
- R2: A ctl_we write arms the command only when ctl_wdata[6:0] equals 7'b0001001. Bit 7 has no effect on this. Any other written value leaves the block disarmed, so a following load returns pm_data and ld_override stays 0.
- R3: Take edge k as the edge that captures the arming write. A store_stb sampled at edge k+1, k+2, k+3 or k+4 is accepted. A store_stb at edge k+5 or later is ignored.
- R4: An accepted store sets boot_lock to boot_lock & r0_data[5:2]. boot_lock[3..0] hold the bits in the order BLB12, BLB11, BLB02, BLB01. A zero in R0 programs the matching bit. A one leaves it as it is, so no bit ever returns to 1. zptr has no effect on a store.
- R5: A load_stb at edge k+1, k+2 or k+3 is a command read. ld_override is 1 during exactly those three cycles and is 0 from the cycle before edge k+4 onward.
- R6: A command read with zptr == 16'h0001 returns {2'b11, BLB12, BLB11, BLB02, BLB01, LB2, LB1}. With zptr == 16'h0000 it returns fuse_low, and with any other zptr it returns 8'hFF. The result is on rd_data in the cycle after the strobe edge.
- R7: An accepted store or command read ends the window, so the next strobe behaves as if no command had been written. With no accepted strobe, the window closes after edge k+4.
- R8: While ee_busy is 1, store and load strobes are not taken as commands and ld_override is 0. boot_lock stays unchanged, and a load returns pm_data.
- R9: A load_stb that is not a command read loads pm_data into rd_data, visible in the cycle after the edge.
- R10: Each arming write restarts the cycle count. The window is always measured from the most recent write.
- R11: LB2 and LB1 (lock_byte[1:0]) change only under reset, where they take hw_lock. r0_data[1:0] has no effect on them.
- R12: A strobe in the same cycle as a ctl_we write is not taken as a command. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| store_stb | input | 1 | Program-store instruction strobe |
| load_stb | input | 1 | Load-program-memory instruction strobe |
| zptr | input | 16 | Z pointer value |
| r0_data | input | 8 | R0 register value |
| ee_busy | input | 1 | EEPROM write in progress |
| fuse_low | input | 8 | Fuse low byte value |
| hw_lock | input | 2 | LB2, LB1 value loaded during reset |
| pm_data | input | 8 | Normal program-memory read data |
| boot_lock | output | 4 | Boot lock bits BLB12, BLB11, BLB02, BLB01 |
| lock_byte | output | 8 | Full lock byte as seen by a read |
| rd_data | output | 8 | Load result register |
| ld_override | output | 1 | Load path taken over by this block |

## Verification
Each result has a fixed due time. ld_override is a combinational output of the window state, so it is checked 1 ns after the strobe is driven and before the edge that samples the strobe. rd_data and boot_lock each pass through one register, so they are checked at the falling edge right after the strobe edge. Strobe delays are counted in edges from the edge that captures the arming write. The table holds delays on both sides of each window limit (three edges and four edges, four edges and five edges), and a bench model predicts the lock bits and the load result from the requirements.

// File: rtl/spm_win_pkg.sv
package spm_win_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BLB_W  = 4;
  localparam int unsigned LB_W   = 2;

  typedef logic [BYTE_W-1:0] byte_t;

  // Code that arms the lock command; bit 7 is ignored.
  localparam logic [6:0] LOCK_CMD_CODE = 7'b0001001;

  function automatic logic is_lock_cmd(input byte_t v);
    return v[6:0] == LOCK_CMD_CODE;
  endfunction

  // Programming only clears bits: zero in r0[5:2] programs.
  function automatic logic [BLB_W-1:0] burn_lock(input logic [BLB_W-1:0] cur,
                                                 input byte_t r0);
    return cur & r0[5:2];
  endfunction

  function automatic byte_t pack_lock(input logic [BLB_W-1:0] blc,
                                      input logic [LB_W-1:0]  lb);
    return {2'b11, blc, lb};
  endfunction

  function automatic byte_t pick_read(input logic  cmd_rd,
                                      input logic  z_is_one,
                                      input logic  z_is_zero,
                                      input byte_t lock_v,
                                      input byte_t fuse_v,
                                      input byte_t pm_v);
    if (!cmd_rd)        return pm_v;
    else if (z_is_one)  return lock_v;
    else if (z_is_zero) return fuse_v;
    else                return 8'hFF;
  endfunction

endpackage

// File: rtl/spm_arm_window.sv
module spm_arm_window
  import spm_win_pkg::*;
#(
  parameter int unsigned STORE_WIN = 4,
  parameter int unsigned LOAD_WIN  = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctl_we,
  input  byte_t ctl_wdata,
  input  logic  store_stb,
  input  logic  load_stb,
  input  logic  ee_busy,
  output logic  armed,
  output logic  ld_open,
  output logic  st_ok,
  output logic  ld_ok
);

  localparam int unsigned CNT_W = $clog2(STORE_WIN + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STORE_WIN - 1);

  logic [CNT_W-1:0] cnt;
  logic             st_open;
  logic             at_last;

  assign st_open = armed && (32'(cnt) < STORE_WIN);
  assign ld_open = armed && (32'(cnt) < LOAD_WIN);
  assign at_last = (cnt == LAST);

  assign st_ok = store_stb && st_open && !ee_busy && !ctl_we;
  assign ld_ok = load_stb  && ld_open && !ee_busy && !ctl_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (ctl_we) begin
      armed <= is_lock_cmd(ctl_wdata);
      cnt   <= '0;
    end else if (armed) begin
      if (st_ok || ld_ok || at_last) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R3: count never leaves the store window while armed
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (32'(cnt) < STORE_WIN));

  // R7: window closes on its last cycle
  a_r7_expire: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && at_last && !ctl_we) |=> !armed);

  // R7: accepted command ends the window
  a_r7_consume: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ok || ld_ok) |=> !armed);

  // R2: idle stays idle without a write
  a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ctl_we) |=> !armed);

  // R10: valid write restarts the count
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && is_lock_cmd(ctl_wdata)) |=> (armed && cnt == '0));

endmodule

// File: rtl/spm_lock_bank.sv
module spm_lock_bank
  import spm_win_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LB_W-1:0]  hw_lock,
  input  logic             st_ok,
  input  byte_t            r0_data,
  output logic [BLB_W-1:0] boot_lock,
  output byte_t            lock_byte
);

  logic [LB_W-1:0] lb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_lock <= '1;
      lb_q      <= hw_lock;
    end else if (st_ok) begin
      boot_lock <= burn_lock(boot_lock, r0_data);
    end
  end

  assign lock_byte = pack_lock(boot_lock, lb_q);

  // R4: no boot lock bit ever returns to 1
  a_r4_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_lock & ~$past(boot_lock)) == '0);

  // R11: general lock bits stay put outside reset
  a_r11_lb_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(lb_q));

endmodule

// File: rtl/spm_readback.sv
module spm_readback
  import spm_win_pkg::*;
#(
  parameter int unsigned Z_W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_stb,
  input  logic           ld_ok,
  input  logic [Z_W-1:0] zptr,
  input  byte_t          lock_byte,
  input  byte_t          fuse_low,
  input  byte_t          pm_data,
  output byte_t          rd_data
);

  logic  z_one;
  logic  z_zero;
  byte_t rd_next;

  assign z_one   = (zptr == Z_W'(1));
  assign z_zero  = (zptr == '0);
  assign rd_next = pick_read(ld_ok, z_one, z_zero, lock_byte, fuse_low, pm_data);

  always_ff @(posedge clk) begin
    if (!rst_n)        rd_data <= '0;
    else if (load_stb) rd_data <= rd_next;
  end

  // R9: plain load passes program-memory data
  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (load_stb && !ld_ok) |=> (rd_data == $past(pm_data)));

  // R6: no strobe keeps the result register
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && $past(rst_n)) |=> $stable(rd_data));

endmodule

// File: rtl/spm_cmd_window.sv
module spm_cmd_window
  import spm_win_pkg::*;
#(
  parameter int unsigned STORE_WIN = 4,
  parameter int unsigned LOAD_WIN  = 3,
  parameter int unsigned Z_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             store_stb,
  input  logic             load_stb,
  input  logic [Z_W-1:0]   zptr,
  input  logic [7:0]       r0_data,
  input  logic             ee_busy,
  input  logic [7:0]       fuse_low,
  input  logic [1:0]       hw_lock,
  input  logic [7:0]       pm_data,
  output logic [3:0]       boot_lock,
  output logic [7:0]       lock_byte,
  output logic [7:0]       rd_data,
  output logic             ld_override
);

  logic armed;
  logic ld_open;
  logic st_ok;
  logic ld_ok;

  spm_arm_window #(
    .STORE_WIN (STORE_WIN),
    .LOAD_WIN  (LOAD_WIN)
  ) u_win (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .store_stb (store_stb),
    .load_stb  (load_stb),
    .ee_busy   (ee_busy),
    .armed     (armed),
    .ld_open   (ld_open),
    .st_ok     (st_ok),
    .ld_ok     (ld_ok)
  );

  spm_lock_bank u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_lock   (hw_lock),
    .st_ok     (st_ok),
    .r0_data   (r0_data),
    .boot_lock (boot_lock),
    .lock_byte (lock_byte)
  );

  spm_readback #(.Z_W(Z_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .ld_ok     (ld_ok),
    .zptr      (zptr),
    .lock_byte (lock_byte),
    .fuse_low  (fuse_low),
    .pm_data   (pm_data),
    .rd_data   (rd_data)
  );

  assign ld_override = ld_open && !ee_busy;

  // R8: EEPROM write blocks lock programming
  a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ee_busy |=> $stable(boot_lock));

  // R5: override only inside an armed window
  a_r5_override_armed: assert property (@(posedge clk) disable iff (!rst_n)
    ld_override |-> armed);

  // R12: a strobe beside a write changes no lock bit
  a_r12_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> $stable(boot_lock));

endmodule

// File: tb/spm_cmd_window_test.sv
module spm_cmd_window_test;

  localparam logic [7:0] FUSE = 8'h5E;
  localparam logic [1:0] HWL  = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic        store_stb = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] zptr = '0;
  logic [7:0]  r0_data = 8'hFF;
  logic        ee_busy = 1'b0;
  logic [7:0]  pm_data = '0;
  logic [3:0]  boot_lock;
  logic [7:0]  lock_byte;
  logic [7:0]  rd_data;
  logic        ld_override;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [3:0] mblc;

  spm_cmd_window uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .store_stb(store_stb), .load_stb(load_stb), .zptr(zptr),
    .r0_data(r0_data), .ee_busy(ee_busy), .fuse_low(FUSE),
    .hw_lock(HWL), .pm_data(pm_data), .boot_lock(boot_lock),
    .lock_byte(lock_byte), .rd_data(rd_data), .ld_override(ld_override)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic [3:0]  dly;
    logic        st;
    logic [15:0] z;
    logic [7:0]  r0;
    logic [7:0]  pm;
    logic [7:0]  cmd;
  } vec_t;

  localparam vec_t VEC [0:9] = '{
    '{4'd1, 1'b1, 16'hABCD, 8'hFB, 8'h00, 8'h09},
    '{4'd5, 1'b1, 16'h0001, 8'h00, 8'h00, 8'h89},
    '{4'd3, 1'b0, 16'h0001, 8'hFF, 8'h11, 8'h09},
    '{4'd4, 1'b0, 16'h0001, 8'hFF, 8'h5A, 8'h09},
    '{4'd1, 1'b0, 16'h0000, 8'hFF, 8'h22, 8'h89},
    '{4'd4, 1'b1, 16'h0000, 8'hEF, 8'h00, 8'h09},
    '{4'd2, 1'b0, 16'h1234, 8'hFF, 8'h33, 8'h09},
    '{4'd2, 1'b1, 16'h0000, 8'hFF, 8'h00, 8'h09},
    '{4'd2, 1'b0, 16'h0001, 8'hFF, 8'h44, 8'h09},
    '{4'd3, 1'b1, 16'h0000, 8'hC3, 8'h00, 8'h09}
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run = n_run + 1;
    if (got !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mblc = 4'hF;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = d;
    @(posedge clk);
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  // pulse one strobe; caller is at a falling edge
  task automatic pulse(input logic st, input logic [15:0] z, input logic [7:0] r0,
                       input logic [7:0] pm);
    zptr = z; r0_data = r0; pm_data = pm;
    if (st) store_stb = 1'b1; else load_stb = 1'b1;
    #1;
  endtask

  task automatic finish_pulse();
    @(posedge clk);
    @(negedge clk);
    store_stb = 1'b0;
    load_stb = 1'b0;
  endtask

  function automatic logic [7:0] exp_read(input logic ok, input logic [15:0] z,
                                          input logic [7:0] pm);
    if (!ok) return pm;
    if (z == 16'h0001) return {2'b11, mblc, HWL};
    if (z == 16'h0000) return FUSE;
    return 8'hFF;
  endfunction

  initial begin
    mblc = 4'hF;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1 override", {7'd0, ld_override}, 8'h00);
    chk("R1 boot_lock", {4'd0, boot_lock}, 8'h0F);
    chk("R1 lock_byte", lock_byte, {2'b11, 4'hF, HWL});
    chk("R1 rd_data", rd_data, 8'h00);

    // table: R3 R4 R5 R6 R9 across window limits
    for (int i = 0; i < 10; i++) begin
      logic ok;
      wr(VEC[i].cmd);
      repeat (int'(VEC[i].dly) - 1) @(negedge clk);
      ok = VEC[i].st ? (VEC[i].dly <= 4) : (VEC[i].dly <= 3);
      pulse(VEC[i].st, VEC[i].z, VEC[i].r0, VEC[i].pm);
      if (VEC[i].st) begin
        finish_pulse();
        if (ok) mblc = mblc & VEC[i].r0[5:2];
        chk($sformatf("R3 R4 store row %0d", i), {4'd0, boot_lock}, {4'd0, mblc});
      end else begin
        chk($sformatf("R5 override row %0d", i), {7'd0, ld_override}, {7'd0, ok});
        finish_pulse();
        chk($sformatf("R6 R9 load row %0d", i), rd_data, exp_read(ok, VEC[i].z, VEC[i].pm));
      end
      repeat (6) @(negedge clk);
    end

    // R2: non-matching code does not arm
    do_reset();
    wr(8'h19);
    pulse(1'b0, 16'h0001, 8'hFF, 8'h77);
    chk("R2 override", {7'd0, ld_override}, 8'h00);
    finish_pulse();
    chk("R2 load", rd_data, 8'h77);

    // R7: read ends the window
    wr(8'h09);
    pulse(1'b0, 16'h0000, 8'hFF, 8'h12);
    finish_pulse();
    chk("R7 first read", rd_data, FUSE);
    chk("R7 override after", {7'd0, ld_override}, 8'h00);
    pulse(1'b0, 16'h0000, 8'hFF, 8'h34);
    finish_pulse();
    chk("R7 second read", rd_data, 8'h34);

    // R8: EEPROM busy blocks both
    ee_busy = 1'b1;
    wr(8'h09);
    pulse(1'b1, 16'h0000, 8'h00, 8'h00);
    chk("R8 override", {7'd0, ld_override}, 8'h00);
    finish_pulse();
    chk("R8 store", {4'd0, boot_lock}, 8'h0F);
    pulse(1'b0, 16'h0001, 8'hFF, 8'h66);
    finish_pulse();
    chk("R8 load", rd_data, 8'h66);
    ee_busy = 1'b0;
    repeat (6) @(negedge clk);

    // R11: r0[1:0] does not reach LB2/LB1
    wr(8'h09);
    pulse(1'b1, 16'h0000, 8'hFC, 8'h00);
    finish_pulse();
    chk("R11 lock_byte", lock_byte, {2'b11, 4'hF, HWL});
    repeat (6) @(negedge clk);

    // R10: rewrite restarts the count
    wr(8'h09);
    repeat (2) @(negedge clk);
    wr(8'h09);
    repeat (3) @(negedge clk);
    pulse(1'b1, 16'h0000, 8'hDF, 8'h00);
    finish_pulse();
    chk("R10 store after rewrite", {4'd0, boot_lock}, 8'h07);
    repeat (6) @(negedge clk);

    // R12: strobe beside a write is not a command
    wr(8'h09);
    ctl_we = 1'b1; ctl_wdata = 8'h09;
    pulse(1'b1, 16'h0000, 8'h00, 8'h00);
    finish_pulse();
    ctl_we = 1'b0;
    chk("R12 store with write", {4'd0, boot_lock}, 8'h07);
    pulse(1'b1, 16'h0000, 8'hFB, 8'h00);
    finish_pulse();
    chk("R12 still armed", {4'd0, boot_lock}, 8'h06);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule